// File: doc/BRIEF.md
# Peripheral Staging FIFO Flush and Discard Controller

This block sits beside a 64-byte staging FIFO that gathers bytes arriving from a parallel peripheral on their way to system memory. It decides when the FIFO contents have to be pushed out to memory and when they have to be thrown away. Several conditions can start a flush:
- the FIFO byte count reaching a programmable burst size;
- the interrupt-pending status bit rising;
- most CPU writes to the port's registers;
- the reset or invalidate control bits being set;
- the current address being reloaded from the next-address register.

While a memory error is outstanding, no flush is ever requested. In that state, the reset, invalidate and reload events discard the FIFO instead.

A flush is presented to the DMA side as a request with a byte count, and the request is held until the DMA side acknowledges it. A threshold flush asks for exactly one burst. Every other flush asks for all bytes currently present. Triggers that arrive while a request is outstanding are folded into it. A discard is signalled with a one-cycle invalidate pulse. The FIFO storage, the DMA master and the register file live outside this block and appear only as ports.

Top module: `fifo_flush_ctrl`

## Requirements
- R1: While `rst_n` is low, `drain_req`, `drain_bytes` and `inval_pulse` are all 0.
- R2: With `mem_err` low and no request outstanding, a byte count `fill` at or above the burst size raises `drain_req` one cycle later, with `drain_bytes` equal to the burst size. The burst size is 4 for `burst_sel`=0, 16 for 1, and 32 for 2 and for 3.
- R3: A rising edge of `irq_pend` counts as a flush event. Holding `irq_pend` high causes no further events.
- R4: A `reg_wr` strobe counts as a flush event, with two exceptions. Register code `reg_sel`=3 (test CSR) never counts. Code 1 (address register) does not count while `diag` is 1. All other codes count.
- R5: A `rst_set` or `inv_set` strobe counts as a flush event.
- R6: An `addr_reload` strobe counts as a flush event only while `diag` is 0.
- R7: With no request outstanding and `mem_err` low, a flush event raises `drain_req` one cycle later with `drain_bytes` equal to `fill`. If `fill` is 0, no request is raised. An event takes precedence over the threshold.
- R8: Once raised, `drain_req` stays high until a cycle with `drain_ack` high. It is low in the following cycle, and triggers present in the acknowledge cycle are absorbed.
- R9: While a request is outstanding, a flush event with nonzero `fill` updates `drain_bytes` to `fill` one cycle later. A threshold hit changes nothing.
- R10: In the cycle after any cycle with `mem_err` high, `drain_req` is 0 and `drain_bytes` is 0. An outstanding request is withdrawn.
- R11: A cycle with `mem_err` high and any of `rst_set`, `inv_set`, or (`addr_reload` with `diag` 0) gives `inval_pulse`=1 in the next cycle. Otherwise `inval_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill | input | 7 | Bytes currently held in the FIFO (0..64) |
| burst_sel | input | 2 | Burst size select |
| irq_pend | input | 1 | Interrupt-pending status bit |
| reg_wr | input | 1 | CPU register write strobe |
| reg_sel | input | 3 | Code of the register being written |
| rst_set | input | 1 | Reset control bit being set |
| inv_set | input | 1 | Invalidate control bit being set |
| addr_reload | input | 1 | Current address reloaded from next address |
| diag | input | 1 | Diagnostic mode |
| mem_err | input | 1 | Memory-error-pending flag |
| drain_ack | input | 1 | DMA side accepts the outstanding request |
| drain_req | output | 1 | Flush request |
| drain_bytes | output | 7 | Bytes to flush for the outstanding request |
| inval_pulse | output | 1 | One-cycle FIFO discard |

## Verification
The hardest situation to reach is the merge: an event has to land while a request is already outstanding and unacknowledged, with a different `fill`, so that `drain_bytes` visibly moves. A mixed variant of this has the memory error arrive during an outstanding request. Directed sequences raise a threshold request, hold `drain_ack` low, and then fire an invalidate or a memory error with a new fill value. The random phase keeps `drain_ack` low most of the time so that requests linger and collisions with fresh events occur often.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  localparam int FIFO_BYTES = 64;
  localparam int CNT_W      = $clog2(FIFO_BYTES + 1);
  localparam int SEL_W      = 3;
  localparam int BSEL_W     = 2;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [SEL_W-1:0] {
    REG_CTRL = 3'd0,
    REG_ADDR = 3'd1,
    REG_NEXT = 3'd2,
    REG_TEST = 3'd3
  } reg_code_e;

  function automatic cnt_t burst_bytes(input logic [BSEL_W-1:0] sel);
    case (sel)
      2'd0:    burst_bytes = cnt_t'(4);
      2'd1:    burst_bytes = cnt_t'(16);
      default: burst_bytes = cnt_t'(32);
    endcase
  endfunction
endpackage

// File: rtl/fdc_events.sv
module fdc_events
  import fdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_pend,
  input  logic             reg_wr,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             rst_set,
  input  logic             inv_set,
  input  logic             addr_reload,
  input  logic             diag,
  output logic             flush_evt,
  output logic             clear_evt
);
  logic irq_q, irq_d;
  logic wr_counts, reload_counts, irq_rise;

  always_comb begin
    irq_d = irq_pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  always_comb begin
    irq_rise      = irq_pend & ~irq_q;
    wr_counts     = reg_wr
                    & (reg_sel != REG_TEST)
                    & ~((reg_sel == REG_ADDR) & diag);
    reload_counts = addr_reload & ~diag;
    clear_evt     = rst_set | inv_set | reload_counts;
    flush_evt     = irq_rise | wr_counts | clear_evt;
  end

  AST_IRQ_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend && $past(irq_pend) && !reg_wr && !clear_evt |-> !flush_evt); // R3
endmodule

// File: rtl/fdc_thresh.sv
module fdc_thresh
  import fdc_pkg::*;
(
  input  logic [BSEL_W-1:0] burst_sel,
  input  cnt_t              fill,
  output logic              thr_hit,
  output cnt_t              thr_bytes
);
  always_comb begin
    thr_bytes = burst_bytes(burst_sel);
    thr_hit   = (fill >= thr_bytes);
  end

  always_comb begin
    AST_THR_NONZERO: assert (!thr_hit || fill != '0); // R2
  end
endmodule

// File: rtl/fdc_request.sv
module fdc_request
  import fdc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cnt_t fill,
  input  logic thr_hit,
  input  cnt_t thr_bytes,
  input  logic flush_evt,
  input  logic clear_evt,
  input  logic mem_err,
  input  logic drain_ack,
  output logic drain_req,
  output cnt_t drain_bytes,
  output logic inval_pulse
);
  logic pend_q, pend_d, inv_q, inv_d;
  cnt_t bytes_q, bytes_d;
  logic evt_live;

  always_comb begin
    evt_live = flush_evt & (fill != '0);
    pend_d   = pend_q;
    bytes_d  = bytes_q;
    inv_d    = 1'b0;
    if (mem_err) begin
      pend_d  = 1'b0;
      bytes_d = '0;
      inv_d   = clear_evt;
    end else if (pend_q) begin
      if (drain_ack) begin
        pend_d  = 1'b0;
        bytes_d = '0;
      end else if (evt_live) begin
        bytes_d = fill;
      end
    end else if (evt_live) begin
      pend_d  = 1'b1;
      bytes_d = fill;
    end else if (thr_hit) begin
      pend_d  = 1'b1;
      bytes_d = thr_bytes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      bytes_q <= '0;
      inv_q   <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      bytes_q <= bytes_d;
      inv_q   <= inv_d;
    end
  end

  assign drain_req   = pend_q;
  assign drain_bytes = bytes_q;
  assign inval_pulse = inv_q;

  AST_NO_REQ_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_err |=> !drain_req); // R10
  AST_HOLD_TILL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req && !drain_ack && !mem_err |=> drain_req); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req && drain_ack |=> !drain_req); // R8
  AST_REQ_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req |-> drain_bytes != '0); // R7
endmodule

// File: rtl/fifo_flush_ctrl.sv
module fifo_flush_ctrl
  import fdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  fill,
  input  logic [BSEL_W-1:0] burst_sel,
  input  logic              irq_pend,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              rst_set,
  input  logic              inv_set,
  input  logic              addr_reload,
  input  logic              diag,
  input  logic              mem_err,
  input  logic              drain_ack,
  output logic              drain_req,
  output logic [CNT_W-1:0]  drain_bytes,
  output logic              inval_pulse
);
  logic flush_evt, clear_evt, thr_hit;
  cnt_t thr_bytes;

  fdc_events u_events (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .rst_set(rst_set), .inv_set(inv_set),
    .addr_reload(addr_reload), .diag(diag),
    .flush_evt(flush_evt), .clear_evt(clear_evt)
  );

  fdc_thresh u_thresh (
    .burst_sel(burst_sel), .fill(fill),
    .thr_hit(thr_hit), .thr_bytes(thr_bytes)
  );

  fdc_request u_request (
    .clk(clk), .rst_n(rst_n), .fill(fill), .thr_hit(thr_hit),
    .thr_bytes(thr_bytes), .flush_evt(flush_evt), .clear_evt(clear_evt),
    .mem_err(mem_err), .drain_ack(drain_ack),
    .drain_req(drain_req), .drain_bytes(drain_bytes),
    .inval_pulse(inval_pulse)
  );

  AST_INVAL_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    inval_pulse |-> $past(mem_err)); // R11
  AST_INVAL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    inval_pulse |-> !drain_req); // R10
endmodule

// File: tb/fifo_flush_ctrl_test.sv
`timescale 1ns/1ps
module fifo_flush_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] fill;
  logic [1:0] burst_sel;
  logic       irq_pend, reg_wr, rst_set, inv_set, addr_reload, diag, mem_err, drain_ack;
  logic [2:0] reg_sel;
  logic       drain_req, inval_pulse;
  logic [6:0] drain_bytes;

  int checks = 0;
  int fails  = 0;

  logic       m_pend, m_inv, m_irq;
  logic [6:0] m_bytes;

  always #5 clk = ~clk;

  fifo_flush_ctrl uut (
    .clk(clk), .rst_n(rst_n), .fill(fill), .burst_sel(burst_sel),
    .irq_pend(irq_pend), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .rst_set(rst_set), .inv_set(inv_set), .addr_reload(addr_reload),
    .diag(diag), .mem_err(mem_err), .drain_ack(drain_ack),
    .drain_req(drain_req), .drain_bytes(drain_bytes), .inval_pulse(inval_pulse)
  );

  function automatic logic [6:0] thr_of(input logic [1:0] s);
    return (s == 2'd0) ? 7'd4 : (s == 2'd1) ? 7'd16 : 7'd32;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_strobes();
    reg_wr = 0; rst_set = 0; inv_set = 0; addr_reload = 0; drain_ack = 0;
  endtask

  // reference model step from current inputs, then one clock
  task automatic cyc();
    logic evt, clr, n_pend, n_inv;
    logic [6:0] n_bytes;
    clr = rst_set | inv_set | (addr_reload & ~diag);
    evt = (irq_pend & ~m_irq) | clr |
          (reg_wr & (reg_sel != 3'd3) & ~((reg_sel == 3'd1) & diag));
    n_pend = m_pend; n_bytes = m_bytes; n_inv = 0;
    if (mem_err) begin
      n_pend = 0; n_bytes = 0; n_inv = clr;
    end else if (m_pend) begin
      if (drain_ack) begin n_pend = 0; n_bytes = 0; end
      else if (evt && fill != 0) n_bytes = fill;
    end else if (evt && fill != 0) begin
      n_pend = 1; n_bytes = fill;
    end else if (fill >= thr_of(burst_sel)) begin
      n_pend = 1; n_bytes = thr_of(burst_sel);
    end
    @(posedge clk);
    m_pend = n_pend; m_bytes = n_bytes; m_inv = n_inv; m_irq = irq_pend;
    @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 0; fill = 0; burst_sel = 2; irq_pend = 0; reg_sel = 0;
    diag = 0; mem_err = 0; clear_strobes();
    m_pend = 0; m_bytes = 0; m_inv = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    chk("R1 req", drain_req, 0); chk("R1 bytes", drain_bytes, 0);
    chk("R1 inval", inval_pulse, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 threshold
    burst_sel = 1; fill = 15; cyc(); chk("R2 below", drain_req, 0);
    fill = 16; cyc(); chk("R2 req", drain_req, 1); chk("R2 bytes", drain_bytes, 16);
    fill = 20; cyc(); chk("R9 thr no change", drain_bytes, 16);
    drain_ack = 1; fill = 3; burst_sel = 2; cyc(); clear_strobes();
    chk("R8 ack clears", drain_req, 0);

    // R7 zero fill suppresses
    fill = 0; reg_wr = 1; reg_sel = 0; cyc(); clear_strobes();
    chk("R7 zero", drain_req, 0);

    // R4 register writes
    fill = 5; reg_wr = 1; reg_sel = 3; cyc(); clear_strobes();
    chk("R4 test csr", drain_req, 0);
    diag = 1; reg_wr = 1; reg_sel = 1; cyc(); clear_strobes();
    chk("R4 addr diag", drain_req, 0);
    diag = 0; reg_wr = 1; reg_sel = 1; cyc(); clear_strobes();
    chk("R4 addr req", drain_req, 1); chk("R7 bytes fill", drain_bytes, 5);
    cyc(); chk("R8 hold", drain_req, 1);
    drain_ack = 1; reg_wr = 1; reg_sel = 0; cyc(); clear_strobes();
    chk("R8 absorbed", drain_req, 0);

    // R3 interrupt edge
    fill = 7; irq_pend = 1; cyc(); chk("R3 edge", drain_req, 1); chk("R3 bytes", drain_bytes, 7);
    drain_ack = 1; cyc(); clear_strobes();
    cyc(); chk("R3 level", drain_req, 0);
    irq_pend = 0;

    // R9 merge
    burst_sel = 0; fill = 4; cyc(); chk("R9 thr req", drain_bytes, 4);
    burst_sel = 2; fill = 9; inv_set = 1; cyc(); clear_strobes();
    chk("R9 merged", drain_bytes, 9); chk("R5 inv held", drain_req, 1);
    drain_ack = 1; cyc(); clear_strobes();

    // R6 reload
    fill = 3; diag = 1; addr_reload = 1; cyc(); clear_strobes();
    chk("R6 diag", drain_req, 0);
    diag = 0; addr_reload = 1; cyc(); clear_strobes();
    chk("R6 req", drain_req, 1); chk("R6 bytes", drain_bytes, 3);

    // R10 memory error withdraws
    mem_err = 1; cyc(); chk("R10 withdraw", drain_req, 0); chk("R10 bytes", drain_bytes, 0);
    reg_wr = 1; reg_sel = 0; cyc(); clear_strobes();
    chk("R10 no req", drain_req, 0); chk("R11 no discard", inval_pulse, 0);
    // R11 discard
    rst_set = 1; cyc(); clear_strobes();
    chk("R11 pulse", inval_pulse, 1); chk("R10 still none", drain_req, 0);
    cyc(); chk("R11 single", inval_pulse, 0);
    diag = 1; addr_reload = 1; cyc(); clear_strobes();
    chk("R11 reload diag", inval_pulse, 0);
    diag = 0; mem_err = 0;

    // R5 reset bit
    fill = 2; rst_set = 1; cyc(); clear_strobes();
    chk("R5 rst", drain_req, 1); chk("R11 no err", inval_pulse, 0);
    drain_ack = 1; cyc(); clear_strobes();

    // random phase
    for (int i = 0; i < 3000; i++) begin
      fill        = 7'($urandom_range(0, 64));
      burst_sel   = 2'($urandom_range(0, 3));
      irq_pend    = ($urandom_range(0, 7) == 0);
      reg_wr      = ($urandom_range(0, 5) == 0);
      reg_sel     = 3'($urandom_range(0, 5));
      rst_set     = ($urandom_range(0, 15) == 0);
      inv_set     = ($urandom_range(0, 15) == 0);
      addr_reload = ($urandom_range(0, 9) == 0);
      diag        = ($urandom_range(0, 3) == 0);
      mem_err     = ($urandom_range(0, 9) == 0);
      drain_ack   = ($urandom_range(0, 3) == 0);
      cyc();
      chk("R8 rand req", drain_req, m_pend);
      chk("R9 rand bytes", drain_bytes, m_bytes);
      chk("R11 rand inval", inval_pulse, m_inv);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule